// File: doc/BRIEF.md
# Receive Frame Admission Filter

This block sits at the end of an Ethernet receive path and makes the final keep-or-drop decision for each frame. It does not look up addresses itself. When the receiver reaches the end of a frame, it presents the frame length together with a set of flags. The flags say whether the destination was the broadcast address, whether the address table reported a hit, and which line errors were seen. The block combines these with the port's mode bits and returns one verdict and a status word for the receive descriptor.

The decision has two stages. The address stage is decided first. Promiscuous operation wins over everything else. Next, broadcast frames are either rejected or taken, depending on the reject-broadcast bit. All other frames are taken on a table hit, and on a miss they are passed or discarded according to a default bit. The error stage then looks at line errors and length errors. A frame that carries any error is dropped unless pass-bad-frames is enabled, and even then it must have passed the address stage. The largest legal length is chosen by a 2-bit selector. A frame below the minimum Ethernet size is marked as short.

The verdict and the status word are registered. They appear one clock after the end-of-frame strobe, together with a one-cycle valid pulse, and they hold their values until the next strobe.

Top module: `rx_admit_filter`

## Requirements
- R1: While reset is asserted and directly after it, `admit_valid`, `admit` and `stat_word` are all 0.
- R2: `admit_valid` is high for exactly the one cycle that follows a cycle with `frame_end` high. `admit` and `stat_word` change only in that cycle. When `frame_end` is low, changes on the other inputs are ignored.
- R3: When not promiscuous, a frame that is not broadcast is accepted on `addr_hit`=1. On a miss it is accepted only when `cfg_miss_pass`=1.
- R4: With `cfg_promisc`=1, an error-free frame is accepted whatever its address, broadcast or table result, and regardless of `cfg_rej_bcast`.
- R5: When not promiscuous, a broadcast frame is dropped if `cfg_rej_bcast`=1 and accepted if `cfg_rej_bcast`=0, without regard to the table result.
- R6: A frame with any error (status bit 15 set) is dropped when `cfg_pass_bad`=0. When `cfg_pass_bad`=1 it is accepted only if the address stage accepts it.
- R7: Status bit 7 (too long) is set when `frame_len` exceeds the limit picked by `cfg_max_len_sel`: 0→1518, 1→1536, 2→2048, 3→65535. A length equal to the limit does not set it.
- R8: Status bit 8 (too short) is set when `frame_len` < 64. A length of 64 does not set it.
- R9: The status word copies `crc_err` to bit 0, `coll_err` to bit 1, `late_coll` to bit 5 and `overrun` to bit 6.
- R10: Status bit 15 is the OR of bits 0, 1, 5, 6, 7 and 8. All other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_end | input | 1 | End-of-frame strobe, one cycle |
| frame_len | input | 16 | Frame length in bytes, CRC included |
| is_bcast | input | 1 | Destination is the broadcast address |
| addr_hit | input | 1 | Address table reported a match |
| crc_err | input | 1 | CRC check failed |
| coll_err | input | 1 | Collision seen during reception |
| late_coll | input | 1 | Late collision seen |
| overrun | input | 1 | Receive overrun |
| cfg_promisc | input | 1 | Accept every destination |
| cfg_rej_bcast | input | 1 | Drop broadcast frames |
| cfg_pass_bad | input | 1 | Let errored frames through the error stage |
| cfg_miss_pass | input | 1 | Accept frames that miss the table |
| cfg_max_len_sel | input | 2 | Selects the maximum-length limit |
| admit_valid | output | 1 | Verdict strobe, one cycle after frame_end |
| admit | output | 1 | 1 = hand frame to DMA, 0 = drop |
| stat_word | output | 16 | Per-frame status bits |

## Verification
The vector table goes through every branch of the address stage. It uses table hit and miss with both settings of the default bit, broadcast with and without rejection, and promiscuous operation on top of each. This confirms that the precedence holds and that no lower rule can override a higher one. Errored frames are tried with pass-bad-frames off, with it on after a hit, and with it on after a miss. This separates the error gate from the address gate. Lengths sit exactly on each of the four limits and one byte above them, and also at 63 and 64 bytes, so that an off-by-one comparison or a swapped selector code shows up. Directed tests cover how the outputs hold between strobes and what reset clears.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int STAT_W      = 16;
  localparam int B_CRC       = 0;
  localparam int B_COLL      = 1;
  localparam int B_LATE      = 5;
  localparam int B_OVR       = 6;
  localparam int B_LONG      = 7;
  localparam int B_SHORT     = 8;
  localparam int B_SUM       = 15;
  localparam int N_LEN_SEL   = 4;

  // Largest legal frame length, CRC included, for each selector code.
  function automatic int size_limit(input int sel);
    case (sel)
      0:       return 1518;
      1:       return 1536;
      2:       return 2048;
      default: return 65535;
    endcase
  endfunction
endpackage

// File: rtl/rxf_len_check.sv
module rxf_len_check #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       sel,
  output logic             too_long,
  output logic             too_short
);
  localparam int LEN_MAX = (1 << LEN_W) - 1;

  logic [LEN_W-1:0] lim [rxf_pkg::N_LEN_SEL];

  for (genvar g = 0; g < rxf_pkg::N_LEN_SEL; g++) begin : g_lim
    localparam int RAW = rxf_pkg::size_limit(g);
    assign lim[g] = (RAW > LEN_MAX) ? LEN_W'(LEN_MAX) : LEN_W'(RAW);
  end

  always_comb begin
    too_long  = len > lim[sel];
    too_short = len < LEN_W'(MIN_LEN);
  end
endmodule

// File: rtl/rxf_addr_gate.sv
module rxf_addr_gate (
  input  logic is_bcast,
  input  logic addr_hit,
  input  logic promisc,
  input  logic rej_bcast,
  input  logic miss_pass,
  output logic addr_ok
);
  // Precedence: promiscuous, then broadcast rule, then table/default.
  always_comb begin
    if (promisc)       addr_ok = 1'b1;
    else if (is_bcast) addr_ok = ~rej_bcast;
    else               addr_ok = addr_hit | miss_pass;
  end
endmodule

// File: rtl/rxf_status_pack.sv
module rxf_status_pack (
  input  logic                       crc_err,
  input  logic                       coll_err,
  input  logic                       late_coll,
  input  logic                       overrun,
  input  logic                       too_long,
  input  logic                       too_short,
  output logic [rxf_pkg::STAT_W-1:0] stat,
  output logic                       any_err
);
  import rxf_pkg::*;

  always_comb begin
    stat            = '0;
    stat[B_CRC]     = crc_err;
    stat[B_COLL]    = coll_err;
    stat[B_LATE]    = late_coll;
    stat[B_OVR]     = overrun;
    stat[B_LONG]    = too_long;
    stat[B_SHORT]   = too_short;
    any_err         = crc_err | coll_err | late_coll | overrun | too_long | too_short;
    stat[B_SUM]     = any_err;
  end
endmodule

// File: rtl/rx_admit_filter.sv
module rx_admit_filter #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_end,
  input  logic [LEN_W-1:0]           frame_len,
  input  logic                       is_bcast,
  input  logic                       addr_hit,
  input  logic                       crc_err,
  input  logic                       coll_err,
  input  logic                       late_coll,
  input  logic                       overrun,
  input  logic                       cfg_promisc,
  input  logic                       cfg_rej_bcast,
  input  logic                       cfg_pass_bad,
  input  logic                       cfg_miss_pass,
  input  logic [1:0]                 cfg_max_len_sel,
  output logic                       admit_valid,
  output logic                       admit,
  output logic [rxf_pkg::STAT_W-1:0] stat_word
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic too_long, too_short, addr_ok, any_err;
  logic [rxf_pkg::STAT_W-1:0] stat_new;

  rxf_len_check #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_len (
    .len(frame_len), .sel(cfg_max_len_sel),
    .too_long(too_long), .too_short(too_short)
  );

  rxf_addr_gate u_addr (
    .is_bcast(is_bcast), .addr_hit(addr_hit), .promisc(cfg_promisc),
    .rej_bcast(cfg_rej_bcast), .miss_pass(cfg_miss_pass), .addr_ok(addr_ok)
  );

  rxf_status_pack u_stat (
    .crc_err(crc_err), .coll_err(coll_err), .late_coll(late_coll),
    .overrun(overrun), .too_long(too_long), .too_short(too_short),
    .stat(stat_new), .any_err(any_err)
  );

  // Next-state logic
  logic                       valid_d, admit_d;
  logic [rxf_pkg::STAT_W-1:0] stat_d;
  logic                       data_en;

  always_comb begin
    data_en = frame_end;
    valid_d = frame_end;
    admit_d = addr_ok & (~any_err | cfg_pass_bad);
    stat_d  = stat_new;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      admit_valid <= 1'b0;
    end else begin
      admit_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      admit     <= 1'b0;
      stat_word <= '0;
    end else if (data_en) begin
      admit     <= admit_d;
      stat_word <= stat_d;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int LEN_W = 16
) (
  input logic                       clk,
  input logic                       rst_ok,
  input logic                       frame_end,
  input logic [LEN_W-1:0]           frame_len,
  input logic                       is_bcast,
  input logic                       crc_err,
  input logic                       coll_err,
  input logic                       late_coll,
  input logic                       overrun,
  input logic                       cfg_promisc,
  input logic                       cfg_rej_bcast,
  input logic                       cfg_pass_bad,
  input logic                       admit_valid,
  input logic                       admit,
  input logic [rxf_pkg::STAT_W-1:0] stat_word
);
  a_r2_valid_after_end: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_end |=> admit_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_ok)
    !frame_end |=> !admit_valid);

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_ok)
    !frame_end |=> ($stable(stat_word) && $stable(admit)));

  a_r10_summary_or: assert property (@(posedge clk) disable iff (!rst_ok)
    admit_valid |-> (stat_word[15] == (|{stat_word[8:5], stat_word[1:0]})));

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    admit_valid |-> (stat_word[14:9] == '0 && stat_word[4:2] == '0));

  a_r6_error_dropped: assert property (@(posedge clk) disable iff (!rst_ok)
    (frame_end && !cfg_pass_bad && (crc_err || coll_err || late_coll || overrun)) |=> !admit);

  a_r5_bcast_rejected: assert property (@(posedge clk) disable iff (!rst_ok)
    (frame_end && !cfg_promisc && cfg_rej_bcast && is_bcast) |=> !admit);

  a_r4_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_ok)
    (frame_end && cfg_promisc && !crc_err && !coll_err && !late_coll && !overrun
     && frame_len >= LEN_W'(64) && frame_len <= LEN_W'(1518)) |=> admit);

  a_r9_crc_copied: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_end |=> (stat_word[0] == $past(crc_err)));
endmodule

bind rx_admit_filter rxf_checker #(.LEN_W(LEN_W)) u_rxf_checker (
  .clk(clk), .rst_ok(rst_sync_n), .frame_end(frame_end), .frame_len(frame_len),
  .is_bcast(is_bcast), .crc_err(crc_err), .coll_err(coll_err),
  .late_coll(late_coll), .overrun(overrun), .cfg_promisc(cfg_promisc),
  .cfg_rej_bcast(cfg_rej_bcast), .cfg_pass_bad(cfg_pass_bad),
  .admit_valid(admit_valid), .admit(admit), .stat_word(stat_word)
);

// File: tb/test_rx_admit_filter.sv
module test_rx_admit_filter;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk, rst_n, frame_end;
  logic [15:0] frame_len;
  logic        is_bcast, addr_hit, crc_err, coll_err, late_coll, overrun;
  logic        cfg_promisc, cfg_rej_bcast, cfg_pass_bad, cfg_miss_pass;
  logic [1:0]  cfg_max_len_sel;
  logic        admit_valid, admit;
  logic [15:0] stat_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  rx_admit_filter i_rx_admit_filter (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_len(frame_len),
    .is_bcast(is_bcast), .addr_hit(addr_hit), .crc_err(crc_err),
    .coll_err(coll_err), .late_coll(late_coll), .overrun(overrun),
    .cfg_promisc(cfg_promisc), .cfg_rej_bcast(cfg_rej_bcast),
    .cfg_pass_bad(cfg_pass_bad), .cfg_miss_pass(cfg_miss_pass),
    .cfg_max_len_sel(cfg_max_len_sel), .admit_valid(admit_valid),
    .admit(admit), .stat_word(stat_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector layout, 48 bits:
  // [47:32] len | {bcast,hit,crc,coll} | {late,ovr,promisc,rej} |
  // {pass_bad,miss_pass,sel[1:0]} | {3'b0,exp_admit} | [15:0] exp_stat
  localparam int NV = 23;
  localparam logic [47:0] VECS [NV] = '{
    48'h0100_4001_0000, // R3 hit
    48'h0100_0000_0000, // R3 miss, default discard
    48'h0100_0041_0000, // R3 miss, default pass
    48'h0100_8001_0000, // R5 broadcast taken
    48'h0100_C100_0000, // R5 broadcast rejected despite hit
    48'h0100_8301_0000, // R4 promisc overrides reject
    48'h0100_0201_0000, // R4 promisc miss
    48'h0100_6000_8001, // R6 crc dropped
    48'h0100_6081_8001, // R6 crc passed after hit
    48'h0100_2080_8001, // R6 crc on miss still dropped
    48'h0100_5C81_8062, // R9 coll/late/overrun bits
    48'h003F_4000_8100, // R8 63 bytes short
    48'h0040_4001_0000, // R8 64 bytes ok
    48'h05EE_4001_0000, // R7 1518 sel0
    48'h05EF_4000_8080, // R7 1519 sel0
    48'h0600_4011_0000, // R7 1536 sel1
    48'h0601_4010_8080, // R7 1537 sel1
    48'h0800_4021_0000, // R7 2048 sel2
    48'h0801_4020_8080, // R7 2049 sel2
    48'hFFFF_4031_0000, // R7 65535 sel3
    48'h0801_4031_0000, // R7 2049 sel3
    48'h0100_2200_8001, // R6 promisc crc dropped
    48'h000A_0281_8100  // R10 promisc short passed
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [47:0] v);
    frame_len       = v[47:32];
    {is_bcast, addr_hit, crc_err, coll_err}            = v[31:28];
    {late_coll, overrun, cfg_promisc, cfg_rej_bcast}   = v[27:24];
    {cfg_pass_bad, cfg_miss_pass, cfg_max_len_sel}     = v[23:20];
  endtask

  initial begin
    rst_n = 1'b0; frame_end = 1'b0;
    apply(48'h0);
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'b0, admit_valid}, 32'd0);
    check("R1 stat in reset", {16'b0, stat_word}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", {15'b0, admit_valid, admit, stat_word}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      check($sformatf("R2 valid vec %0d", i), {31'b0, admit_valid}, 32'd1);
      check($sformatf("R3-6 admit vec %0d", i), {31'b0, admit}, {31'b0, VECS[i][16]});
      check($sformatf("R7-10 stat vec %0d", i), {16'b0, stat_word}, {16'b0, VECS[i][15:0]});
    end

    // R2: inputs ignored without the strobe; outputs hold
    apply(48'h003F_6000_0000);
    @(negedge clk);
    check("R2 valid drops", {31'b0, admit_valid}, 32'd0);
    check("R2 stat held", {16'b0, stat_word}, 32'h8100);
    check("R2 admit held", {31'b0, admit}, 32'd1);
    repeat (3) @(negedge clk);
    check("R2 still held", {15'b0, admit_valid, admit, stat_word}, 32'h0001_8100);

    // R2: back-to-back strobes
    apply(48'h0100_4001_0000);
    frame_end = 1'b1;
    @(negedge clk);
    check("R2 b2b first", {15'b0, admit_valid, admit, stat_word}, 32'h0003_0000);
    apply(48'h0100_6000_8001);
    @(negedge clk);
    frame_end = 1'b0;
    check("R2 b2b second", {15'b0, admit_valid, admit, stat_word}, 32'h0002_8001);

    // R1: reset clears held state
    apply(48'h0100_4001_0000);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", {15'b0, admit_valid, admit, stat_word}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule